// File: doc/BRIEF.md
# Bridge-Sensor Front-End Control Logic

This block is the digital state of an eight-channel bridge-sensor front end. A serial-bus slave in front of it turns each bus transaction into a decoded access. An access is a valid strobe, a write/read flag, an 8-bit address and up to 16 bits of write data. The block keeps the settings and drives the static control lines of the analog circuits. These lines carry the amplifier gain code, the one-hot input-channel select, the signed offset code of the active channel, the regulator voltage select and enable, the output-mux select, an analog power-down line and an analog-ready flag.

Some state is changed by the address of a write alone, with no data. Such writes select a channel, turn on current-sense output, sleep, wake, reset or do nothing. The offset is stored per channel, and only the selected channel's code reaches the DAC pins. In sleep, most writes are dropped. Two settling counters hold analog-ready low after a write that changes the analog state, and for a longer time after waking. Both counter lengths are derived from the clock frequency.

Top module: `afe_ctrl`

## Requirements
- R1: After reset, gain_code is 0, chan_sel is 8'h01, offset_code is 0, ldo_vsel is 0, ldo_en is 1, sense_sel is 0, analog_pd is 0 and analog_ready is 1.
- R2: Each read access is answered one cycle later by a one-cycle rd_valid pulse. Address 0x02 returns 16'h8910. Address 0x03 returns {4'b0, hardware version in 11:8 (default 0), software version in 7:0 (default 1)}, which is 16'h0001. Addresses with no register return 0.
- R3: A write to 0x06 keeps wdata[2:0] as the gain code on gain_code (code 0..7 = gain 2, 20, 40, 80, 150, 300, 600, 760). The other bits are dropped, and a read of 0x06 returns the code zero-extended.
- R4: A write to 0x10, 0x12, 0x14, 0x15, 0x18, 0x1A, 0x1C or 0x1E selects channel 1..8 in that order. chan_sel bit n-1 is set for channel n, and chan_sel is always one-hot.
- R5: A write to 0x08 sets sense_sel to 1. It stays 1 through any other access until a channel-select write or a software reset clears it.
- R6: Writes to 0x20, 0x22, 0x24, 0x25, 0x28, 0x2A, 0x2C or 0x2E store wdata[10:0] as the offset of channel 1..8, with bit 10 the sign (1 negative) and bits 9:0 the magnitude. Upper bits are dropped, and reads return the stored 11 bits. offset_code shows the selected channel's value one cycle after it or the selection changes.
- R7: A write to 0x07 keeps wdata[0] as ldo_vsel (1 = lower voltage) and wdata[1] as the sleep-disable bit. ldo_en is 0 only while asleep with that bit set.
- R8: A write to 0x05 sets analog_pd and forces analog_ready low. While asleep, only writes to 0x04 and 0x07 take effect, reads still answer, and all settings are kept.
- R9: A write to 0x04 while asleep clears analog_pd. analog_ready then reads low for exactly WAKE_CYC cycles (1920 at 200 MHz for 9.6 us) before going high.
- R10: Any other write that takes effect and changes the analog state drives analog_ready low for exactly SETUP_CYC cycles (700 at 200 MHz for 3.5 us). The writes in scope are gain, regulator, offset, channel select, current sense, sleep and software reset.
- R11: A write to 0x01 while awake restores every R1 setting, all eight offsets and the regulator bits. While asleep it is ignored.
- R12: A write to 0x00, or to any address with no function, changes no setting and does not restart the settling counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Decoded access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write or command, 0 = read |
| acc_addr | input | 8 | Register or command address |
| acc_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Read data |
| gain_code | output | 3 | Amplifier gain code |
| chan_sel | output | 8 | One-hot input channel select |
| offset_code | output | 11 | Sign-magnitude offset of active channel |
| ldo_vsel | output | 1 | Regulator voltage select |
| ldo_en | output | 1 | Regulator enable |
| sense_sel | output | 1 | Output mux: 1 = regulator current sense |
| analog_pd | output | 1 | Analog power-down |
| analog_ready | output | 1 | Analog outputs settled |

## Verification
The hardest situation to reach is sleep combined with pending state. The regulator sleep-disable bit must be written while asleep. Writes that would otherwise take effect, including a software reset, a channel select and a current-sense command, must be shown to have no effect. Current-sense mode must survive unrelated writes. The stimulus therefore builds the state before entering sleep. It then issues the filtered writes, reads registers back while asleep, and measures the wake interval cycle by cycle at the ready output. The exit from current-sense mode is reached both by a channel select and by a software reset.

// File: rtl/afe_pkg.sv
package afe_pkg;
  localparam int unsigned NUM_CH = 8;
  localparam int unsigned CH_W   = $clog2(NUM_CH);
  localparam int unsigned OFS_W  = 11;
  localparam int unsigned GAIN_W = 3;

  localparam logic [7:0] A_NOP   = 8'h00;
  localparam logic [7:0] A_SWRST = 8'h01;
  localparam logic [7:0] A_ID    = 8'h02;
  localparam logic [7:0] A_VER   = 8'h03;
  localparam logic [7:0] A_WAKE  = 8'h04;
  localparam logic [7:0] A_SLEEP = 8'h05;
  localparam logic [7:0] A_GAIN  = 8'h06;
  localparam logic [7:0] A_LDO   = 8'h07;
  localparam logic [7:0] A_SENSE = 8'h08;
  localparam logic [3:0] SEL_PAGE = 4'h1;
  localparam logic [3:0] OFS_PAGE = 4'h2;

  typedef struct packed {
    logic            swrst;
    logic            id;
    logic            ver;
    logic            wake;
    logic            sleep;
    logic            gain;
    logic            ldo;
    logic            sense;
    logic            sel;
    logic            ofs;
    logic [CH_W-1:0] ch;
  } dec_t;

  // Low nibble of a channel-page address -> {hit, channel index}.
  function automatic logic [CH_W:0] slot_of(input logic [3:0] lo);
    case (lo)
      4'h0:    slot_of = {1'b1, 3'd0};
      4'h2:    slot_of = {1'b1, 3'd1};
      4'h4:    slot_of = {1'b1, 3'd2};
      4'h5:    slot_of = {1'b1, 3'd3};
      4'h8:    slot_of = {1'b1, 3'd4};
      4'hA:    slot_of = {1'b1, 3'd5};
      4'hC:    slot_of = {1'b1, 3'd6};
      4'hE:    slot_of = {1'b1, 3'd7};
      default: slot_of = '0;
    endcase
  endfunction
endpackage

// File: rtl/afe_cmd_decode.sv
module afe_cmd_decode
  import afe_pkg::*;
(
  input  logic [7:0] addr,
  output dec_t       dec
);
  logic [CH_W:0] slot;

  always_comb begin
    slot      = slot_of(addr[3:0]);
    dec       = '0;
    dec.swrst = (addr == A_SWRST);
    dec.id    = (addr == A_ID);
    dec.ver   = (addr == A_VER);
    dec.wake  = (addr == A_WAKE);
    dec.sleep = (addr == A_SLEEP);
    dec.gain  = (addr == A_GAIN);
    dec.ldo   = (addr == A_LDO);
    dec.sense = (addr == A_SENSE);
    dec.sel   = (addr[7:4] == SEL_PAGE) && slot[CH_W];
    dec.ofs   = (addr[7:4] == OFS_PAGE) && slot[CH_W];
    dec.ch    = slot[CH_W-1:0];
  end
endmodule

// File: rtl/afe_offset_bank.sv
module afe_offset_bank #(
  parameter int unsigned NCH = 8,
  parameter int unsigned W   = 11,
  localparam int unsigned IW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ridx,
  output logic [W-1:0]  rdata,
  input  logic [IW-1:0] act_idx,
  output logic [W-1:0]  act_q
);
  logic [W-1:0] mem [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst || clr)
        mem[g] <= '0;
      else if (we && widx == IW'(g))
        mem[g] <= wdata;
    end
  end

  assign rdata = mem[ridx];

  always_ff @(posedge clk) begin
    if (rst) act_q <= '0;
    else     act_q <= mem[act_idx];
  end

  assert_clr_zero_R11: assert property (@(posedge clk) disable iff (rst)
    clr |=> (mem[widx] == '0));
endmodule

// File: rtl/afe_ready_timer.sv
module afe_ready_timer #(
  parameter int unsigned SETUP_CYC = 700,
  parameter int unsigned WAKE_CYC  = 1920,
  localparam int unsigned MAXC = (SETUP_CYC > WAKE_CYC) ? SETUP_CYC : WAKE_CYC,
  localparam int unsigned CW   = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load_setup,
  input  logic load_wake,
  input  logic hold_low,
  output logic ready_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      ready_o <= 1'b1;
    end else if (load_wake) begin
      cnt_q   <= CW'(WAKE_CYC);
      ready_o <= 1'b0;
    end else if (load_setup) begin
      cnt_q   <= CW'(SETUP_CYC);
      ready_o <= 1'b0;
    end else if (cnt_q > CW'(1)) begin
      cnt_q   <= cnt_q - 1'b1;
      ready_o <= 1'b0;
    end else begin
      cnt_q   <= '0;
      ready_o <= ~hold_low;
    end
  end

  assert_load_low_R10: assert property (@(posedge clk) disable iff (rst)
    (load_setup || load_wake) |=> !ready_o);
  assert_hold_low_R8: assert property (@(posedge clk) disable iff (rst)
    hold_low |=> !ready_o);
endmodule

// File: rtl/afe_ctrl.sv
module afe_ctrl
  import afe_pkg::*;
#(
  parameter longint unsigned CLK_HZ   = 200_000_000,
  parameter longint unsigned SETUP_NS = 3500,
  parameter longint unsigned WAKE_NS  = 9600,
  parameter logic [3:0]      HW_VER   = 4'd0,
  parameter logic [7:0]      SW_VER   = 8'd1,
  parameter logic [15:0]     ID_WORD  = 16'h8910,
  localparam longint unsigned SETUP_RAW = (CLK_HZ / 1000) * SETUP_NS / 1_000_000,
  localparam longint unsigned WAKE_RAW  = (CLK_HZ / 1000) * WAKE_NS / 1_000_000,
  localparam int unsigned SETUP_CYC = (SETUP_RAW < 1) ? 1 : int'(SETUP_RAW),
  localparam int unsigned WAKE_CYC  = (WAKE_RAW < 1) ? 1 : int'(WAKE_RAW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [7:0]        acc_addr,
  input  logic [15:0]       acc_wdata,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  output logic [GAIN_W-1:0] gain_code,
  output logic [NUM_CH-1:0] chan_sel,
  output logic [OFS_W-1:0]  offset_code,
  output logic              ldo_vsel,
  output logic              ldo_en,
  output logic              sense_sel,
  output logic              analog_pd,
  output logic              analog_ready
);
  dec_t              dec;
  logic              acc_ok, wr_any, rd_any;
  logic              load_setup, load_wake;
  logic [GAIN_W-1:0] gain_q, gain_n;
  logic [1:0]        ldo_q, ldo_n;
  logic [CH_W-1:0]   ch_q, ch_n;
  logic              sense_n, sleep_n;
  logic [OFS_W-1:0]  bank_rdata;

  afe_cmd_decode u_dec (.addr(acc_addr), .dec(dec));

  assign wr_any = acc_valid && acc_write;
  assign rd_any = acc_valid && !acc_write;
  // While asleep only wake and regulator writes pass the filter.
  assign acc_ok = wr_any && (!analog_pd || dec.wake || dec.ldo);

  always_comb begin
    gain_n  = gain_q;
    ldo_n   = ldo_q;
    ch_n    = ch_q;
    sense_n = sense_sel;
    sleep_n = analog_pd;
    if (acc_ok) begin
      if (dec.swrst) begin
        gain_n  = '0;
        ldo_n   = '0;
        ch_n    = '0;
        sense_n = 1'b0;
        sleep_n = 1'b0;
      end
      if (dec.gain)  gain_n  = acc_wdata[GAIN_W-1:0];
      if (dec.ldo)   ldo_n   = acc_wdata[1:0];
      if (dec.sense) sense_n = 1'b1;
      if (dec.sel) begin
        ch_n    = dec.ch;
        sense_n = 1'b0;
      end
      if (dec.sleep) sleep_n = 1'b1;
      if (dec.wake)  sleep_n = 1'b0;
    end
  end

  assign load_wake  = acc_ok && dec.wake && analog_pd;
  assign load_setup = acc_ok && !load_wake &&
                      (dec.swrst || dec.gain || dec.ldo || dec.sense ||
                       dec.sel || dec.ofs || dec.sleep || dec.wake);

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_q    <= '0;
      ldo_q     <= '0;
      ch_q      <= '0;
      sense_sel <= 1'b0;
      analog_pd <= 1'b0;
      chan_sel  <= NUM_CH'(1);
      ldo_en    <= 1'b1;
    end else begin
      gain_q    <= gain_n;
      ldo_q     <= ldo_n;
      ch_q      <= ch_n;
      sense_sel <= sense_n;
      analog_pd <= sleep_n;
      chan_sel  <= NUM_CH'(1) << ch_n;
      ldo_en    <= ~sleep_n | ~ldo_n[1];
    end
  end

  assign gain_code = gain_q;
  assign ldo_vsel  = ldo_q[0];

  afe_offset_bank #(.NCH(NUM_CH), .W(OFS_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .clr    (acc_ok && dec.swrst),
    .we     (acc_ok && dec.ofs),
    .widx   (dec.ch),
    .wdata  (acc_wdata[OFS_W-1:0]),
    .ridx   (dec.ch),
    .rdata  (bank_rdata),
    .act_idx(ch_q),
    .act_q  (offset_code)
  );

  afe_ready_timer #(.SETUP_CYC(SETUP_CYC), .WAKE_CYC(WAKE_CYC)) u_rdy (
    .clk       (clk),
    .rst       (rst),
    .load_setup(load_setup),
    .load_wake (load_wake),
    .hold_low  (sleep_n),
    .ready_o   (analog_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_any;
      if (rd_any) begin
        rd_data <= '0;
        if (dec.id)   rd_data <= ID_WORD;
        if (dec.ver)  rd_data <= {4'b0, HW_VER, SW_VER};
        if (dec.gain) rd_data <= 16'(gain_q);
        if (dec.ldo)  rd_data <= 16'(ldo_q);
        if (dec.ofs)  rd_data <= 16'(bank_rdata);
      end
    end
  end

  assert_chan_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(chan_sel) == 1);
  assert_sense_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (sense_sel && !(acc_ok && (dec.sel || dec.swrst))) |=> sense_sel);
  assert_ldo_awake_R7: assert property (@(posedge clk) disable iff (rst)
    !analog_pd |-> ldo_en);
  assert_sleep_filter_R8: assert property (@(posedge clk) disable iff (rst)
    (analog_pd && wr_any && !dec.wake && !dec.ldo) |=>
      ($stable(gain_code) && $stable(chan_sel) && $stable(sense_sel)));
  assert_pd_not_ready_R8: assert property (@(posedge clk) disable iff (rst)
    analog_pd |-> !analog_ready);
  assert_rd_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    rd_any |=> rd_valid);
endmodule

// File: tb/afe_ctrl_tb_top.sv
module afe_ctrl_tb_top;
  localparam int unsigned SETUP_EXP = 700;
  localparam int unsigned WAKE_EXP  = 1920;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [7:0]  acc_addr = '0;
  logic [15:0] acc_wdata = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [2:0]  gain_code;
  logic [7:0]  chan_sel;
  logic [10:0] offset_code;
  logic        ldo_vsel, ldo_en, sense_sel, analog_pd, analog_ready;

  int vectors = 0;
  int miscompares = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] ofs_data [8];

  always #2.5 clk = ~clk;

  afe_ctrl dut_i (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .gain_code(gain_code), .chan_sel(chan_sel),
    .offset_code(offset_code), .ldo_vsel(ldo_vsel), .ldo_en(ldo_en),
    .sense_sel(sense_sel), .analog_pd(analog_pd), .analog_ready(analog_ready)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    access(1'b1, a, d);
  endtask

  // Driver side of the scoreboard: push the expected word, then issue the read.
  task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    access(1'b0, a, 16'h0);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 5000 && !analog_ready; i++) @(negedge clk);
  endtask

  // Called right after a write returns: counts cycles ready stays low.
  task automatic measure_low(input string tag, input int unsigned exp);
    int unsigned n = 0;
    while (!analog_ready && n < 5000) begin
      n++;
      @(negedge clk);
    end
    check(tag, n, exp);
  endtask

  // Monitor side of the scoreboard.
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        vectors++; miscompares++;
        $display("FAIL R2: unexpected read data %h, expected none", rd_data);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rd_data, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle();
    // R1 defaults
    check("R1 gain", gain_code, 0);
    check("R1 chan", chan_sel, 8'h01);
    check("R1 offset", offset_code, 0);
    check("R1 vsel", ldo_vsel, 0);
    check("R1 ldo_en", ldo_en, 1);
    check("R1 sense", sense_sel, 0);
    check("R1 pd", analog_pd, 0);
    check("R1 ready", analog_ready, 1);

    // R2 identity and unmapped reads
    rd(8'h02, 16'h8910, "R2 id");
    rd(8'h03, 16'h0001, "R2 version");
    rd(8'h09, 16'h0000, "R2 unmapped");
    rd(8'h21, 16'h0000, "R2 unmapped channel page");

    // R3 gain with junk upper bits, R10 settling length
    wr(8'h06, 16'hFFFC);
    measure_low("R10 setup after gain", SETUP_EXP);
    check("R3 gain", gain_code, 3'd4);
    rd(8'h06, 16'h0004, "R3 gain readback");

    // R6 per-channel offsets
    for (int i = 0; i < 8; i++)
      ofs_data[i] = 16'hF000 | ((i % 2) ? 16'h0400 : 16'h0) | 16'(i * 113 + 5);
    wr(8'h20, ofs_data[0]); wr(8'h22, ofs_data[1]);
    wr(8'h24, ofs_data[2]); wr(8'h25, ofs_data[3]);
    wr(8'h28, ofs_data[4]); wr(8'h2A, ofs_data[5]);
    wr(8'h2C, ofs_data[6]); wr(8'h2E, ofs_data[7]);
    rd(8'h20, ofs_data[0] & 16'h07FF, "R6 ofs ch1");
    rd(8'h25, ofs_data[3] & 16'h07FF, "R6 ofs ch4");
    rd(8'h2E, ofs_data[7] & 16'h07FF, "R6 ofs ch8");
    settle();
    check("R6 active ch1", offset_code, 11'(ofs_data[0]));

    // R4 channel select, R6 routing
    wr(8'h15, 16'h0);
    settle();
    check("R4 chan4", chan_sel, 8'h08);
    check("R6 active ch4", offset_code, 11'(ofs_data[3]));
    wr(8'h1E, 16'h0);
    settle();
    check("R4 chan8", chan_sel, 8'h80);
    check("R6 active ch8", offset_code, 11'(ofs_data[7]));

    // R5 current sense persistence
    wr(8'h08, 16'h0);
    settle();
    check("R5 sense on", sense_sel, 1);
    wr(8'h06, 16'h0002);
    wr(8'h2C, 16'h0123);
    ofs_data[6] = 16'h0123;
    settle();
    check("R5 sense kept", sense_sel, 1);
    wr(8'h12, 16'h0);
    settle();
    check("R5 sense cleared by select", sense_sel, 0);
    check("R4 chan2", chan_sel, 8'h02);

    // R7 regulator
    wr(8'h07, 16'hFFFD);
    settle();
    check("R7 vsel", ldo_vsel, 1);
    check("R7 ldo_en awake", ldo_en, 1);
    rd(8'h07, 16'h0001, "R7 readback");

    // R8 sleep filtering
    wait_ready();
    wr(8'h05, 16'h0);
    settle();
    check("R8 pd", analog_pd, 1);
    check("R8 ready low", analog_ready, 0);
    check("R7 ldo_en sleep enabled", ldo_en, 1);
    wr(8'h06, 16'h0007);
    wr(8'h18, 16'h0);
    wr(8'h08, 16'h0);
    wr(8'h2A, 16'h0555);
    wr(8'h01, 16'h0);
    settle();
    check("R8 gain kept", gain_code, 3'd2);
    check("R8 chan kept", chan_sel, 8'h02);
    check("R8 sense kept", sense_sel, 0);
    check("R11 reset ignored asleep", analog_pd, 1);
    rd(8'h06, 16'h0002, "R8 read while asleep");
    rd(8'h2A, ofs_data[5] & 16'h07FF, "R8 offset kept");
    wr(8'h07, 16'h0003);
    settle();
    check("R7 ldo_en sleep disabled", ldo_en, 0);
    check("R7 vsel asleep", ldo_vsel, 1);

    // R9 wake
    wr(8'h04, 16'h0);
    measure_low("R9 wake interval", WAKE_EXP);
    check("R9 pd cleared", analog_pd, 0);
    check("R7 ldo_en after wake", ldo_en, 1);

    // R12 no-op and unmapped writes
    wait_ready();
    wr(8'h00, 16'hFFFF);
    check("R12 nop ready", analog_ready, 1);
    wr(8'h30, 16'hFFFF);
    check("R12 unmapped ready", analog_ready, 1);
    settle();
    check("R12 gain unchanged", gain_code, 3'd2);
    check("R12 chan unchanged", chan_sel, 8'h02);

    // R11 software reset
    wr(8'h08, 16'h0);
    wr(8'h14, 16'h0);
    wr(8'h08, 16'h0);
    wait_ready();
    wr(8'h01, 16'h0);
    measure_low("R10 setup after reset", SETUP_EXP);
    check("R11 gain", gain_code, 0);
    check("R11 chan", chan_sel, 8'h01);
    check("R11 sense", sense_sel, 0);
    check("R11 offset", offset_code, 0);
    check("R11 vsel", ldo_vsel, 0);
    rd(8'h07, 16'h0000, "R11 ldo bits");
    rd(8'h25, 16'h0000, "R11 ofs ch4");
    settle();
    check("R2 scoreboard drained", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule